// File: doc/BRIEF.md
# Deterministic Shared-Memory Slot Allocator

This block decides which of eight cores may use a shared memory on each clock. A slot counter steps through a rotation of 32 slots, one per clock. In fixed mode every core owns every eighth slot, so each core gets one access in eight clocks without any setup. In negotiated mode an owner table sets slot ownership. Cores enter the table through launch requests that ask for a bandwidth class.

A launch names a core and a class: one access every 4, 8, 16 or 32 slots. The allocator scans candidate phases from the lowest upward, one phase per clock. It takes the first phase whose slots are all unowned and writes the core into every slot of that phase. If no phase is free, or the core is already active, the launch is refused and the table does not change. A release clears every slot of a core in one clock. After a grant the core's accesses come at a fixed interval, with no contention at run time.

Top module: `slot_alloc`

## Requirements
- R1: `slot_idx` is 0 after reset, rises by one each clock, and wraps from 31 to 0.
- R2: With `alloc_mode` = 0, `slot_grant` is 1 and `slot_owner` equals `slot_idx` mod 8 on every clock, whatever the table holds.
- R3: `launch_class` codes 0, 1, 2 and 3 request one access every 4, 8, 16 and 32 slots.
- R4: A granted launch of interval N owns exactly the slots whose index mod N equals the returned `resp_phase`. That phase is the lowest one whose slots were all unowned. With `alloc_mode` = 1, `slot_owner` shows the owning core on those slots.
- R5: When no phase of the requested class is free, the response has `resp_ok` = 0 and the table is unchanged.
- R6: A launch for a core that already holds slots is refused (`resp_ok` = 0) and the table is unchanged.
- R7: A release removes every slot of the named core in one clock. With `alloc_mode` = 1, an unowned slot gives `slot_grant` = 0.
- R8: `busy` is 1 from the clock after a launch is accepted through the response clock. The response comes at most 33 clocks after acceptance. A launch presented while `busy` is 1 is ignored.
- R9: `resp_valid` is a single-clock pulse per accepted launch.
- R10: After reset the table is empty, `busy` is 0 and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_mode | input | 1 | 0: fixed 1-in-8 rotation, 1: owner table |
| launch_valid | input | 1 | Launch request strobe |
| launch_core | input | 3 | Core being launched |
| launch_class | input | 2 | Bandwidth class code |
| release_valid | input | 1 | Release strobe |
| release_core | input | 3 | Core being released |
| busy | output | 1 | Launch pending or response in progress |
| resp_valid | output | 1 | Launch response strobe |
| resp_ok | output | 1 | 1 if the launch was granted |
| resp_phase | output | 5 | Phase granted (0 on refusal) |
| slot_idx | output | 5 | Current slot number |
| slot_grant | output | 1 | Current slot has an owner |
| slot_owner | output | 3 | Owner of the current slot |

## Verification
The assertions check the local invariants on every clock. These are the slot counter's step and wrap, the rule that a write never lands on an owned slot, that a release leaves no slot with the released core, that the phase scan stays inside its interval, and that the response lasts one clock. Only the bench's scenarios can show the rest. This covers the choice of the lowest free phase, refusals that leave the table untouched, launches ignored while busy, and the fixed-mode rotation as seen through the slot outputs.

// File: rtl/slot_pkg.sv
package slot_pkg;
    parameter int SLOT_COUNT   = 32;
    parameter int CORE_COUNT   = 8;
    parameter int CLASS_COUNT  = 4;
    parameter int MIN_INTERVAL = 4;

    localparam int SLOT_W  = $clog2(SLOT_COUNT);
    localparam int CORE_W  = $clog2(CORE_COUNT);
    localparam int CLASS_W = $clog2(CLASS_COUNT);
    localparam int IVL_W   = SLOT_W + 1;

    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [CORE_W-1:0]  core_t;
    typedef logic [CLASS_W-1:0] class_t;
    typedef logic [IVL_W-1:0]   ivl_t;

    typedef struct packed {
        logic  valid;
        core_t core;
    } entry_t;

    typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;

    // interval in slots for a class code: MIN_INTERVAL doubled per step
    function automatic ivl_t interval_of(class_t c);
        return ivl_t'(MIN_INTERVAL) << c;
    endfunction
endpackage

// File: rtl/slot_counter.sv
module slot_counter
    import slot_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_t slot
);
    localparam slot_t LAST = slot_t'(SLOT_COUNT - 1);

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = (slot_q == LAST) ? '0 : slot_q + slot_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot = slot_q;

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == LAST) |=> (slot_q == '0)); // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != LAST) |=> (slot_q == $past(slot_q) + slot_t'(1))); // R1
endmodule

// File: rtl/owner_table.sv
module owner_table
    import slot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SLOT_COUNT-1:0] wr_mask,
    input  core_t                 wr_core,
    input  logic                  rel_en,
    input  core_t                 rel_core,
    input  slot_t                 rd_idx,
    output logic [SLOT_COUNT-1:0] valid_vec,
    output entry_t                rd_entry
);
    entry_t [SLOT_COUNT-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        for (int s = 0; s < SLOT_COUNT; s++) begin
            if (rel_en && tab_q[s].valid && (tab_q[s].core == rel_core))
                tab_d[s].valid = 1'b0;
            if (wr_en && wr_mask[s]) begin
                tab_d[s].valid = 1'b1;
                tab_d[s].core  = wr_core;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_valid
        assign valid_vec[g] = tab_q[g].valid;
    end

    assign rd_entry = tab_q[rd_idx];

    // checker state: which core was released last cycle (without a refill)
    logic  chk_rel_q;
    core_t chk_core_q;
    logic [SLOT_COUNT-1:0] chk_owned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_rel_q  <= 1'b0;
            chk_core_q <= '0;
        end else begin
            chk_rel_q  <= rel_en && !(wr_en && (wr_core == rel_core));
            chk_core_q <= rel_core;
        end
    end

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_chk
        assign chk_owned[g] = tab_q[g].valid && (tab_q[g].core == chk_core_q);
    end

    AST_NO_DOUBLE_BOOK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_mask & valid_vec) == '0)); // R4
    AST_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        chk_rel_q |-> ($countones(chk_owned) == 0)); // R7
endmodule

// File: rtl/phase_scanner.sv
module phase_scanner
    import slot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch_valid,
    input  core_t                 launch_core,
    input  class_t                launch_class,
    input  logic                  rel_en,
    input  core_t                 rel_core,
    input  logic [SLOT_COUNT-1:0] valid_vec,
    output logic                  busy,
    output logic                  resp_valid,
    output logic                  resp_ok,
    output slot_t                 resp_phase,
    output logic                  wr_en,
    output logic [SLOT_COUNT-1:0] wr_mask,
    output core_t                 wr_core
);
    typedef struct packed {
        scan_st_e              st;
        core_t                 core;
        class_t                cls;
        slot_t                 phase;
        logic [CORE_COUNT-1:0] active;
        logic                  resp_valid;
        logic                  resp_ok;
        slot_t                 resp_phase;
    } scan_state_t;

    scan_state_t d, q;
    ivl_t ivl;
    logic [SLOT_COUNT-1:0] cand_mask;
    logic conflict;
    logic last_phase;

    always_comb begin
        ivl = interval_of(q.cls);
        for (int s = 0; s < SLOT_COUNT; s++)
            cand_mask[s] = ((ivl_t'(s) & (ivl - ivl_t'(1))) == ivl_t'(q.phase));
        conflict   = |(cand_mask & valid_vec);
        last_phase = (ivl_t'(q.phase) == (ivl - ivl_t'(1)));
    end

    always_comb begin
        d            = q;
        d.resp_valid = 1'b0;
        wr_en        = 1'b0;
        wr_mask      = cand_mask;
        wr_core      = q.core;
        if (rel_en) d.active[rel_core] = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (launch_valid && !busy) begin
                    if (q.active[launch_core]) begin
                        d.resp_valid = 1'b1;
                        d.resp_ok    = 1'b0;
                        d.resp_phase = '0;
                    end else begin
                        d.st    = ST_SCAN;
                        d.core  = launch_core;
                        d.cls   = launch_class;
                        d.phase = '0;
                    end
                end
            end
            ST_SCAN: begin
                if (!conflict) begin
                    wr_en             = 1'b1;
                    d.active[q.core]  = 1'b1;
                    d.resp_valid      = 1'b1;
                    d.resp_ok         = 1'b1;
                    d.resp_phase      = q.phase;
                    d.st              = ST_IDLE;
                end else if (last_phase) begin
                    d.resp_valid = 1'b1;
                    d.resp_ok    = 1'b0;
                    d.resp_phase = '0;
                    d.st         = ST_IDLE;
                end else begin
                    d.phase = q.phase + slot_t'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE) || q.resp_valid;
    assign resp_valid = q.resp_valid;
    assign resp_ok    = q.resp_ok;
    assign resp_phase = q.resp_phase;

    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN) |-> (ivl_t'(q.phase) < interval_of(q.cls))); // R8
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R9
    AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ok) |-> !$past(conflict)); // R4
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
    import slot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alloc_mode,
    input  logic        launch_valid,
    input  logic [2:0]  launch_core,
    input  logic [1:0]  launch_class,
    input  logic        release_valid,
    input  logic [2:0]  release_core,
    output logic        busy,
    output logic        resp_valid,
    output logic        resp_ok,
    output logic [4:0]  resp_phase,
    output logic [4:0]  slot_idx,
    output logic        slot_grant,
    output logic [2:0]  slot_owner
);
    slot_t                 slot;
    logic                  wr_en;
    logic [SLOT_COUNT-1:0] wr_mask;
    core_t                 wr_core;
    logic [SLOT_COUNT-1:0] valid_vec;
    entry_t                rd_entry;

    slot_counter u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (slot)
    );

    owner_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_mask  (wr_mask),
        .wr_core  (wr_core),
        .rel_en   (release_valid),
        .rel_core (release_core),
        .rd_idx   (slot),
        .valid_vec(valid_vec),
        .rd_entry (rd_entry)
    );

    phase_scanner u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_valid(launch_valid),
        .launch_core (launch_core),
        .launch_class(launch_class),
        .rel_en      (release_valid),
        .rel_core    (release_core),
        .valid_vec   (valid_vec),
        .busy        (busy),
        .resp_valid  (resp_valid),
        .resp_ok     (resp_ok),
        .resp_phase  (resp_phase),
        .wr_en       (wr_en),
        .wr_mask     (wr_mask),
        .wr_core     (wr_core)
    );

    assign slot_idx   = slot;
    assign slot_grant = alloc_mode ? rd_entry.valid : 1'b1;
    assign slot_owner = alloc_mode ? rd_entry.core : slot[CORE_W-1:0];
endmodule

// File: tb/slot_alloc_test.sv
module slot_alloc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_mode = 1'b1;
    logic       launch_valid = 1'b0;
    logic [2:0] launch_core = '0;
    logic [1:0] launch_class = '0;
    logic       release_valid = 1'b0;
    logic [2:0] release_core = '0;
    logic       busy, resp_valid, resp_ok, slot_grant;
    logic [4:0] resp_phase, slot_idx;
    logic [2:0] slot_owner;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic       m_valid [32];
    logic [2:0] m_core  [32];
    logic       m_active [8];

    always #10 clk = ~clk;

    slot_alloc uut (
        .clk(clk), .rst_n(rst_n), .alloc_mode(alloc_mode),
        .launch_valid(launch_valid), .launch_core(launch_core),
        .launch_class(launch_class), .release_valid(release_valid),
        .release_core(release_core), .busy(busy), .resp_valid(resp_valid),
        .resp_ok(resp_ok), .resp_phase(resp_phase), .slot_idx(slot_idx),
        .slot_grant(slot_grant), .slot_owner(slot_owner)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lowest free phase for interval n, -1 when none
    function automatic int model_phase(input int n);
        for (int p = 0; p < n; p++) begin
            bit ok = 1;
            for (int s = p; s < 32; s += n)
                if (m_valid[s]) ok = 0;
            if (ok) return p;
        end
        return -1;
    endfunction

    task automatic verify_table(input string req);
        alloc_mode = 1'b1;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            check(slot_grant == m_valid[slot_idx], req, slot_grant, m_valid[slot_idx]);
            if (m_valid[slot_idx])
                check(slot_owner == m_core[slot_idx], req, slot_owner, m_core[slot_idx]);
        end
    endtask

    task automatic do_launch(input int core, input int cls, input bit inject);
        int n = 0;
        int exp_ph;
        bit exp_ok;
        int ivl = 4 << cls;  // R3: class code to interval
        exp_ph = m_active[core] ? -1 : model_phase(ivl);
        exp_ok = (exp_ph >= 0);
        @(negedge clk);
        launch_valid = 1'b1; launch_core = 3'(core); launch_class = 2'(cls);
        @(negedge clk);
        launch_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (inject) begin
            launch_valid = 1'b1; launch_core = 3'd6; launch_class = 2'd0;
        end
        while (!resp_valid && n < 40) begin
            @(negedge clk);
            launch_valid = 1'b0;
            n++;
        end
        launch_valid = 1'b0;
        check(n <= 33, "R8 response latency", n, 33);
        check(resp_ok == exp_ok, "R4/R5/R6 resp_ok", resp_ok, exp_ok);
        if (exp_ok) begin
            check(resp_phase == 5'(exp_ph), "R4 lowest phase", resp_phase, exp_ph);
            m_active[core] = 1'b1;
            for (int s = exp_ph; s < 32; s += ivl) begin
                m_valid[s] = 1'b1; m_core[s] = 3'(core);
            end
        end
        @(negedge clk);
        check(resp_valid == 1'b0, "R9 single pulse", resp_valid, 0);
    endtask

    task automatic do_release(input int core);
        @(negedge clk);
        release_valid = 1'b1; release_core = 3'(core);
        @(negedge clk);
        release_valid = 1'b0;
        m_active[core] = 1'b0;
        for (int s = 0; s < 32; s++)
            if (m_valid[s] && m_core[s] == 3'(core)) m_valid[s] = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(slot_idx == 0, "R10 slot_idx in reset", slot_idx, 0);
        check(busy == 0, "R10 busy in reset", busy, 0);
        check(resp_valid == 0, "R10 resp_valid in reset", resp_valid, 0);
        rst_n = 1'b1;
        verify_table("R10 table empty");
    endtask

    task automatic t_counter();
        logic [4:0] prev;
        @(negedge clk);
        prev = slot_idx;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(slot_idx == prev + 5'd1, "R1 slot step/wrap", slot_idx, prev + 5'd1);
            prev = slot_idx;
        end
    endtask

    task automatic t_fixed();
        alloc_mode = 1'b0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            check(slot_grant == 1'b1, "R2 fixed grant", slot_grant, 1);
            check(slot_owner == slot_idx[2:0], "R2 fixed owner", slot_owner, slot_idx[2:0]);
        end
        alloc_mode = 1'b1;
    endtask

    task automatic t_grants();
        do_launch(0, 1, 0);  // R3 1-in-8, phase 0
        do_launch(1, 0, 0);  // R3 1-in-4, phase 1
        do_launch(2, 2, 0);  // R3 1-in-16
        verify_table("R4 table after grants");
    endtask

    task automatic t_fail();
        do_launch(3, 0, 0);  // takes last 1-in-4 phase
        do_launch(4, 0, 0);  // R5 no free phase
        verify_table("R5 table unchanged");
    endtask

    task automatic t_dup();
        do_launch(0, 3, 0);  // R6 core 0 already active
        verify_table("R6 table unchanged");
    endtask

    task automatic t_release();
        do_release(1);
        verify_table("R7 release cleared");
        do_launch(4, 0, 0);  // reuses freed phase
        verify_table("R7 regrant");
    endtask

    task automatic t_busy_ignore();
        do_launch(5, 3, 1);  // R8 injected launch for core 6 ignored
        verify_table("R8 injected launch ignored");
        check(m_active[6] == 1'b0, "R8 model core6 idle", m_active[6], 0);
        do_launch(6, 3, 0);  // succeeds only if core 6 was not made active
        verify_table("R8 core6 later grant");
    endtask

    initial begin
        for (int s = 0; s < 32; s++) begin m_valid[s] = 0; m_core[s] = '0; end
        for (int c = 0; c < 8; c++) m_active[c] = 0;
        t_reset();
        t_counter();
        t_fixed();
        t_grants();
        t_fail();
        t_dup();
        t_release();
        t_busy_ignore();
        t_fixed();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule